// File: doc/BRIEF.md
# Serial Port Transmit/Receive Byte Queue Pair

This block holds the two byte queues that sit between a host and the shift registers of a 16550-style serial port. The host pushes bytes toward the line with a write strobe and takes received bytes with a read strobe. The serializer side sees the oldest transmit byte and acknowledges it. The deserializer side delivers received bytes with a valid strobe. Baud timing, shifting, interrupt encoding and register address decoding belong to neighbouring blocks. The read strobe of the status register is a plain input.

Each queue is 32 bytes deep by default. A global enable switches both queues between full-depth operation and single-byte holding-register operation. A one-cycle clear input per direction empties only that queue. Per-direction threshold selects drive level flags. A 32-bit status word reports both occupancies, two sticky error flags that clear on a status read, and idle indications. A 10-bit line-status word gives the classic empty, full and ready bits.

Top module: `uart_fifo_pair`

## Requirements
- R1: Each queue returns bytes in arrival order. The status word carries the transmit occupancy in bits 29:24 and the receive occupancy in bits 21:16. The oldest transmit byte appears on `tx_head`, and a pop from `host_rdata` returns the oldest received byte.
- R2: A host write while the transmit queue is full is dropped. It sets status bit 3, which stays set until a cycle with `stat_rd` high and then reads 0 on the following cycle.
- R3: A host read while the receive queue is empty returns 0 on `host_rdata` and leaves the occupancy at 0. It sets status bit 2, which clears after a `stat_rd` cycle just as bit 3 does.
- R4: When a flag-setting event and `stat_rd` occur in the same cycle, the flag reads 1 on the next cycle.
- R5: `rx_trig_hit` is high when the receive occupancy exceeds 1, 4, 8 or 16 for `rx_trig_sel` values 0, 1, 2 or 3.
- R6: `tx_trig_hit` is high when the transmit occupancy exceeds 16, 8, 4 or 1 for `tx_trig_sel` values 0, 1, 2 or 3. This is the reverse order of the receive side.
- R7: A one-cycle `rx_clr` or `tx_clr` makes that queue's occupancy 0 on the next cycle. It leaves the other queue's occupancy and contents unchanged. A push or pop in the same cycle as a clear is ignored.
- R8: With `fifo_en` low, each queue holds at most one byte, so its occupancy reads only 0 or 1. A second push is dropped and the first byte is kept.
- R9: A received byte that arrives while the receive queue is full is discarded. `rx_ovr_pulse` is high for exactly the following cycle, and the occupancy stays at full.
- R10: Status bit 0 (transmit idle) is 1 exactly when the transmit queue is empty and `tx_shift_empty` is 1. Status bit 1 (receive idle) is 1 exactly when the receive queue is empty.
- R11: In `line_stat`, bit 9 means receive queue empty and bit 8 means transmit queue full. Bit 6 equals the transmit idle condition, bit 5 means transmit queue empty, and bit 0 means receive data ready. All other bits are 0.
- R12: After reset both queues are empty and both sticky flags are 0. With `tx_shift_empty` high, the status word reads 32'h0000_0003 and `line_stat` reads 10'h260.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: full-depth queues, 0: single-byte holding registers |
| rx_trig_sel | input | 2 | Receive threshold select |
| tx_trig_sel | input | 2 | Transmit threshold select |
| rx_clr | input | 1 | One-cycle receive queue clear |
| tx_clr | input | 1 | One-cycle transmit queue clear |
| host_wr | input | 1 | Host push into transmit queue |
| host_wdata | input | 8 | Byte to push |
| host_rd | input | 1 | Host pop from receive queue |
| host_rdata | output | 8 | Oldest received byte, 0 when empty |
| stat_rd | input | 1 | Status word read strobe |
| tx_head | output | 8 | Oldest transmit byte |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_take | input | 1 | Serializer takes `tx_head` |
| tx_shift_empty | input | 1 | Serializer shift register empty |
| rx_in_valid | input | 1 | Received byte strobe |
| rx_in_data | input | 8 | Received byte |
| rx_ovr_pulse | output | 1 | Received byte discarded, queue full |
| rx_trig_hit | output | 1 | Receive threshold exceeded |
| tx_trig_hit | output | 1 | Transmit threshold exceeded |
| stat_word | output | 32 | Occupancy, sticky error and idle status |
| line_stat | output | 10 | Empty/full/ready line status bits |

## Verification
The hardest conditions to reach are the ones that need a completely full queue while something else happens in the same cycle. Examples are a host write that is dropped while the status register is being read, and a received byte that arrives with no room left. The stimulus fills a queue to its exact depth with back-to-back strobes. It then applies the conflicting strobes together in one cycle and samples the flags on the next cycle. The same fill-then-probe approach is used around each threshold: the trigger vectors place occupancies exactly at a threshold and one above it.

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig_sel,
  input  logic [1:0]       tx_trig_sel,
  input  logic             rx_clr,
  input  logic             tx_clr,
  input  logic             host_wr,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_rd,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             stat_rd,
  output logic [WIDTH-1:0] tx_head,
  output logic             tx_valid,
  input  logic             tx_take,
  input  logic             tx_shift_empty,
  input  logic             rx_in_valid,
  input  logic [WIDTH-1:0] rx_in_data,
  output logic             rx_ovr_pulse,
  output logic             rx_trig_hit,
  output logic             tx_trig_hit,
  output logic [31:0]      stat_word,
  output logic [9:0]       line_stat
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] tx_mem [DEPTH];
  logic [WIDTH-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic tx_ovr, rx_udr;

  wire [CW-1:0] cap = fifo_en ? CW'(DEPTH) : CW'(1);
  wire tx_full  = tx_cnt >= cap;
  wire rx_full  = rx_cnt >= cap;
  wire tx_empty = tx_cnt == '0;
  wire rx_empty = rx_cnt == '0;

  wire tx_push = host_wr & ~tx_full & ~tx_clr;
  wire tx_pop  = tx_take & ~tx_empty & ~tx_clr;
  wire rx_push = rx_in_valid & ~rx_full & ~rx_clr;
  wire rx_pop  = host_rd & ~rx_empty & ~rx_clr;

  function automatic int rx_thr(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic int tx_thr(input logic [1:0] s);
    case (s)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 4;
      default: return 1;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= host_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_in_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_ovr <= 1'b0; rx_udr <= 1'b0; rx_ovr_pulse <= 1'b0;
    end else begin
      tx_ovr       <= (tx_ovr & ~stat_rd) | (host_wr & tx_full);
      rx_udr       <= (rx_udr & ~stat_rd) | (host_rd & rx_empty);
      rx_ovr_pulse <= rx_in_valid & rx_full;
    end

  wire tx_idle = tx_empty & tx_shift_empty;

  assign tx_head     = tx_mem[tx_rp];
  assign tx_valid    = ~tx_empty;
  assign host_rdata  = rx_empty ? '0 : rx_mem[rx_rp];
  assign rx_trig_hit = int'(rx_cnt) > rx_thr(rx_trig_sel);
  assign tx_trig_hit = int'(tx_cnt) > tx_thr(tx_trig_sel);
  assign stat_word   = {2'b0, 6'(tx_cnt), 2'b0, 6'(rx_cnt), 12'b0,
                        tx_ovr, rx_udr, rx_empty, tx_idle};
  assign line_stat   = {rx_empty, tx_full, 1'b0, tx_idle, tx_empty,
                        4'b0, ~rx_empty};

  assert_occupancy_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_cnt) <= DEPTH && int'(rx_cnt) <= DEPTH);
  assert_tx_ovr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && tx_full |=> stat_word[3]);
  assert_tx_ovr_full_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && tx_full && !tx_clr && !tx_take |=> $stable(tx_cnt));
  assert_rx_udr_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && rx_empty |=> stat_word[2]);
  assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_clr || rx_clr |=> (!$past(tx_clr) || tx_cnt == 0) && (!$past(rx_clr) || rx_cnt == 0));
  assert_holding_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en && tx_cnt <= 1 && rx_cnt <= 1 && $past(!fifo_en) |=> !fifo_en || (tx_cnt <= 1 && rx_cnt <= 1));
  assert_rx_drop_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && rx_full |=> rx_ovr_pulse);
endmodule

// File: tb/uart_fifo_pair_bench.sv
module uart_fifo_pair_bench;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n, fifo_en, rx_clr, tx_clr, host_wr, host_rd, stat_rd;
  logic tx_take, tx_shift_empty, rx_in_valid;
  logic [1:0] rx_trig_sel, tx_trig_sel;
  logic [7:0] host_wdata, rx_in_data, host_rdata, tx_head;
  logic tx_valid, rx_ovr_pulse, rx_trig_hit, tx_trig_hit;
  logic [31:0] stat_word;
  logic [9:0] line_stat;

  uart_fifo_pair u_uart_fifo_pair (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_trig_sel(rx_trig_sel),
    .tx_trig_sel(tx_trig_sel), .rx_clr(rx_clr), .tx_clr(tx_clr),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .stat_rd(stat_rd), .tx_head(tx_head),
    .tx_valid(tx_valid), .tx_take(tx_take), .tx_shift_empty(tx_shift_empty),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_ovr_pulse(rx_ovr_pulse), .rx_trig_hit(rx_trig_hit),
    .tx_trig_hit(tx_trig_hit), .stat_word(stat_word), .line_stat(line_stat));

  int nchk = 0, nfail = 0;

  // {trig code, fill count, expected rx trigger, expected tx trigger}
  localparam logic [9:0] VEC [12] = '{
    {2'd0, 6'd1,  1'b0, 1'b0}, {2'd0, 6'd2,  1'b1, 1'b0},
    {2'd1, 6'd4,  1'b0, 1'b0}, {2'd1, 6'd5,  1'b1, 1'b0},
    {2'd2, 6'd5,  1'b0, 1'b1}, {2'd2, 6'd9,  1'b1, 1'b1},
    {2'd3, 6'd2,  1'b0, 1'b1}, {2'd3, 6'd17, 1'b1, 1'b1},
    {2'd0, 6'd17, 1'b1, 1'b1}, {2'd1, 6'd9,  1'b1, 1'b1},
    {2'd3, 6'd1,  1'b0, 1'b0}, {2'd0, 6'd32, 1'b1, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic clear_both;
    tx_clr = 1; rx_clr = 1; step(); tx_clr = 0; rx_clr = 0;
  endtask

  task automatic fill(input int n, input logic to_tx, input logic to_rx, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      host_wr = to_tx; host_wdata = base + 8'(i);
      rx_in_valid = to_rx; rx_in_data = base + 8'(i);
      step();
    end
    host_wr = 0; rx_in_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; fifo_en = 1; rx_clr = 0; tx_clr = 0; host_wr = 0; host_rd = 0;
    stat_rd = 0; tx_take = 0; tx_shift_empty = 1; rx_in_valid = 0;
    rx_trig_sel = 0; tx_trig_sel = 0; host_wdata = 0; rx_in_data = 0;
    step(); step(); rst_n = 1; step();

    chk("R12 reset status", stat_word, 32'h0000_0003);
    chk("R12 reset line", 32'(line_stat), 32'h260);

    // R5 R6 threshold vectors
    for (int v = 0; v < 12; v++) begin
      clear_both();
      rx_trig_sel = VEC[v][9:8]; tx_trig_sel = VEC[v][9:8];
      fill(int'(VEC[v][7:2]), 1, 1, 8'h10);
      chk("R5 rx trigger", 32'(rx_trig_hit), 32'(VEC[v][1]));
      chk("R6 tx trigger", 32'(tx_trig_hit), 32'(VEC[v][0]));
      chk("R1 counts", {stat_word[29:24], stat_word[21:16]}, {20'b0, VEC[v][7:2], VEC[v][7:2]});
    end

    // R1 ordering
    clear_both();
    fill(3, 1, 1, 8'hA1);
    for (int i = 0; i < 3; i++) begin
      chk("R1 rx order", 32'(host_rdata), 32'(8'hA1 + 8'(i)));
      chk("R1 tx order", 32'(tx_head), 32'(8'hA1 + 8'(i)));
      host_rd = 1; tx_take = 1; step(); host_rd = 0; tx_take = 0;
    end
    chk("R1 drained", {stat_word[29:24], stat_word[21:16]}, 32'h0);

    // R2 overrun, sticky, clear on read
    fill(32, 1, 0, 8'h40);
    host_wr = 1; host_wdata = 8'hEE; step(); host_wr = 0;
    chk("R2 count held", 32'(stat_word[29:24]), 32);
    chk("R2 flag set", 32'(stat_word[3]), 1);
    chk("R11 tx full", 32'(line_stat[8]), 1);
    step();
    chk("R2 flag sticky", 32'(stat_word[3]), 1);
    chk("R2 head kept", 32'(tx_head), 32'h40);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R2 flag cleared", 32'(stat_word[3]), 0);

    // R4 event and read together
    host_wr = 1; stat_rd = 1; step(); host_wr = 0; stat_rd = 0;
    chk("R4 same cycle", 32'(stat_word[3]), 1);
    stat_rd = 1; step(); stat_rd = 0;

    // R10 tx idle needs empty queue and empty shifter
    chk("R10 tx idle busy", 32'(stat_word[0]), 0);
    tx_clr = 1; step(); tx_clr = 0;
    chk("R10 tx idle", 32'(stat_word[0]), 1);
    tx_shift_empty = 0; step();
    chk("R10 shifter busy", 32'(stat_word[0]), 0);
    chk("R11 shifter busy line", 32'(line_stat), 32'h220);
    tx_shift_empty = 1;

    // R3 underrun
    rx_clr = 1; step(); rx_clr = 0;
    host_rd = 1; #1;
    chk("R3 empty read data", 32'(host_rdata), 0);
    step(); host_rd = 0;
    chk("R3 flag set", 32'(stat_word[2]), 1);
    chk("R3 count zero", 32'(stat_word[21:16]), 0);
    stat_rd = 1; step(); stat_rd = 0;
    chk("R3 flag cleared", 32'(stat_word[2]), 0);

    // R9 receive drop
    fill(32, 0, 1, 8'h80);
    chk("R10 rx not idle", 32'(stat_word[1]), 0);
    chk("R11 data ready", 32'({line_stat[9], line_stat[0]}), 32'b01);
    rx_in_valid = 1; rx_in_data = 8'h77; step(); rx_in_valid = 0;
    chk("R9 pulse", 32'(rx_ovr_pulse), 1);
    chk("R9 count", 32'(stat_word[21:16]), 32);
    step();
    chk("R9 pulse once", 32'(rx_ovr_pulse), 0);

    // R7 clear only one side
    fill(5, 1, 0, 8'h20);
    rx_clr = 1; step(); rx_clr = 0;
    chk("R7 rx cleared", 32'(stat_word[21:16]), 0);
    chk("R7 tx kept", 32'(stat_word[29:24]), 5);
    chk("R7 tx head kept", 32'(tx_head), 32'h20);
    rx_clr = 1; rx_in_valid = 1; step(); rx_clr = 0; rx_in_valid = 0;
    chk("R7 push during clear ignored", 32'(stat_word[21:16]), 0);

    // R8 holding register mode
    clear_both();
    fifo_en = 0;
    fill(2, 1, 1, 8'h61);
    chk("R8 tx one", 32'(stat_word[29:24]), 1);
    chk("R8 rx one", 32'(stat_word[21:16]), 1);
    chk("R8 first kept", 32'(host_rdata), 32'h61);
    chk("R8 full flag", 32'(line_stat[8]), 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule